// File: doc/BRIEF.md
# Prescaled Match Timer

This peripheral is a free-running up-counter with a programmable prescaler and a single compare channel. Software reaches it through a small register bus. Once started, the main counter advances by one for every (prescale match + 1) input clocks. When it steps onto the value held in the compare register, and the compare interrupt is enabled, a sticky flag is set. The interrupt line stays high for as long as that flag is set.

A match does not stop or restart the counter. A periodic tick is therefore produced by software: on each interrupt it adds one period to the compare register, with the addition wrapping at the counter width, and then clears the flag by writing a one to it. A clear-count control bit forces the counter and the prescaler to zero. A debug-halt enable lets an external debug-active input freeze counting. A capture-control register exists only as storage that can be read and written.

The bus is a simple single-cycle write port with combinational read data. Register word addresses are: 0 control, 1 counter (read only), 2 prescale match, 3 compare, 4 compare enable, 5 capture control, 6 interrupt flags.

Top module: `match_tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While running with prescale match P, the counter advances exactly once every P+1 clocks, starting from the clock after the run bit is set.
- R3: When control bit 0 (run) is zero, the counter and the prescaler hold their values. Setting run again resumes from the held value.
- R4: A control write with bit 1 (clear-count) set makes the counter read zero right after that write. The counter stays at zero while the bit remains set. After the bit is cleared, counting restarts from zero.
- R5: With control bit 2 (debug-halt enable) set, counting freezes while `dbg_active` is high and resumes when it falls. With bit 2 clear, `dbg_active` has no effect.
- R6: When the counter steps onto the compare value while compare-enable bit 0 is set, interrupt flag bit 0 is set on that same edge. With compare-enable clear, no flag is set.
- R7: A match neither stops nor resets the counter. The counter wraps from all ones to zero, and a compare value advanced by one period matches exactly one period later.
- R8: Writing 1 to interrupt bit 0 clears the flag. Writing 0 leaves it unchanged. If a match and a clear happen on the same edge, the flag stays set.
- R9: `irq` is high exactly while interrupt flag bit 0 is set.
- R10: The capture-control register reads back the last value written to it. Writes to the counter address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (zero when not selected) |
| dbg_active | input | 1 | External debugger active |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach from the ports are a compare event landing on the same edge as a write-one-to-clear, and a match that falls across counter wraparound. The bench reaches the first by writing the compare register to two above the live count, so that the next write lands exactly on the matching edge. It reaches the second by building the counter narrower than the default, which lets wraparound occur within about a thousand clocks at prescale zero. Every other sequence is counted in edges from a known write, so each expected counter value follows directly from the prescale ratio.

// File: rtl/match_tick_timer.sv
module match_tick_timer #(
  parameter int CNT_W = 32,
  parameter int PS_W  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        dbg_active,
  output logic        irq
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CNT  = 3'd1;
  localparam logic [2:0] A_PSM  = 3'd2;
  localparam logic [2:0] A_CMP  = 3'd3;
  localparam logic [2:0] A_CEN  = 3'd4;
  localparam logic [2:0] A_CAP  = 3'd5;
  localparam logic [2:0] A_INT  = 3'd6;

  logic [2:0]       ctrl_q;
  logic [PS_W-1:0]  psm_q, pc_q;
  logic [CNT_W-1:0] cnt_q, cmp_q, cnt_nx;
  logic             cen_q, flag_q;
  logic [31:0]      cap_q;

  logic wr, wr_ctrl, wr_int, halt, zero_now, run, pwrap, tick, evt, clr;

  assign wr       = bus_sel & bus_wr;
  assign wr_ctrl  = wr && bus_addr == A_CTRL;
  assign wr_int   = wr && bus_addr == A_INT;
  assign halt     = ctrl_q[2] & dbg_active;
  assign zero_now = ctrl_q[1] | (wr_ctrl & bus_wdata[1]);
  assign run      = ctrl_q[0] & ~halt & ~zero_now;
  assign pwrap    = pc_q >= psm_q;
  assign tick     = run & pwrap;
  assign cnt_nx   = cnt_q + 1'b1;
  assign evt      = tick & cen_q & (cnt_nx == cmp_q);
  assign clr      = wr_int & bus_wdata[0];
  assign irq      = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psm_q  <= '0;
      pc_q   <= '0;
      cnt_q  <= '0;
      cmp_q  <= '0;
      cen_q  <= 1'b0;
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[2:0];
      if (wr && bus_addr == A_PSM) psm_q <= bus_wdata[PS_W-1:0];
      if (wr && bus_addr == A_CMP) cmp_q <= bus_wdata[CNT_W-1:0];
      if (wr && bus_addr == A_CEN) cen_q <= bus_wdata[0];
      if (wr && bus_addr == A_CAP) cap_q <= bus_wdata;
      if (zero_now) begin
        pc_q  <= '0;
        cnt_q <= '0;
      end else if (run) begin
        pc_q <= pwrap ? '0 : pc_q + 1'b1;
        if (pwrap) cnt_q <= cnt_nx;
      end
      flag_q <= evt | (flag_q & ~clr);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = {29'd0, ctrl_q};
        A_CNT:   bus_rdata = 32'(cnt_q);
        A_PSM:   bus_rdata = 32'(psm_q);
        A_CMP:   bus_rdata = 32'(cmp_q);
        A_CEN:   bus_rdata = {31'd0, cen_q};
        A_CAP:   bus_rdata = cap_q;
        A_INT:   bus_rdata = {31'd0, flag_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !zero_now) |=> $stable(cnt_q));

  // R2
  prescale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) |-> ($past(pc_q) >= $past(psm_q)));

  // R4
  zero_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[1]) |=> (cnt_q == '0));

  // R5
  dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !zero_now) |=> $stable(cnt_q));

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag_q);

  // R6
  match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == CNT_W'($past(cnt_q) + 1'b1)) && cnt_q == $past(cmp_q) && $past(cen_q)) |-> flag_q);
endmodule

// File: tb/tb_match_tick_timer.sv
`timescale 1ns/1ps
module tb_match_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, dbg_active = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, fails = 0;

  localparam int NV = 7;
  localparam int VP [NV] = '{0, 3, 3, 12, 12, 12, 1};
  localparam int VN [NV] = '{5, 8, 11, 13, 39, 38, 7};
  localparam int VE [NV] = '{5, 2, 2, 1, 3, 2, 3};

  localparam logic [2:0] CTRL = 0, CNT = 1, PSM = 2, CMP = 3, CEN = 4, CAP = 5, INTF = 6;

  match_tick_timer #(.CNT_W(10), .PS_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_active(dbg_active), .irq(irq));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    tk(3);
    rst_n = 1'b1;
    tk(1);
    for (int a = 0; a < 7; a++) rchk("R1 reg", 3'(a), 0);
    chk("R1 irq", {31'd0, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(CTRL, 2); wr(PSM, VP[i]); wr(CTRL, 1);
      tk(VN[i]);
      rchk("R2 prescale", CNT, VE[i]);
    end

    wr(CTRL, 2); wr(PSM, 0); wr(CTRL, 1);
    tk(6);
    wr(CTRL, 0);
    rchk("R3 stop", CNT, 7);
    tk(20);
    rchk("R3 held", CNT, 7);
    wr(CTRL, 1);
    tk(3);
    rchk("R3 resume", CNT, 10);

    wr(CTRL, 3);
    rchk("R4 zero", CNT, 0);
    tk(5);
    rchk("R4 held zero", CNT, 0);
    wr(CTRL, 1);
    tk(4);
    rchk("R4 restart", CNT, 4);

    wr(CTRL, 5);
    rchk("R5 pre", CNT, 5);
    dbg_active = 1'b1;
    tk(6);
    rchk("R5 halted", CNT, 5);
    dbg_active = 1'b0;
    tk(2);
    rchk("R5 resumed", CNT, 7);
    dbg_active = 1'b1;
    wr(CTRL, 1);
    tk(3);
    rchk("R5 ignored", CNT, 10);
    dbg_active = 1'b0;

    wr(CTRL, 2); wr(CMP, 10); wr(CEN, 1); wr(CTRL, 1);
    tk(9);
    rchk("R6 before", INTF, 0);
    chk("R9 low", {31'd0, irq}, 0);
    tk(1);
    rchk("R6 match", INTF, 1);
    chk("R9 high", {31'd0, irq}, 1);
    tk(2);
    rchk("R7 no reset", CNT, 12);
    wr(CMP, 20);
    wr(INTF, 0);
    rchk("R8 zero write", INTF, 1);
    wr(INTF, 1);
    rchk("R8 clear", INTF, 0);
    chk("R9 cleared", {31'd0, irq}, 0);
    tk(4);
    rchk("R7 next before", INTF, 0);
    tk(1);
    rchk("R7 period", INTF, 1);
    wr(CMP, 22);
    wr(INTF, 1);
    rchk("R8 same edge", INTF, 1);
    wr(INTF, 1);
    rchk("R8 clear2", INTF, 0);
    wr(CEN, 0); wr(CMP, 27);
    tk(3);
    rchk("R6 disabled cnt", CNT, 28);
    rchk("R6 disabled", INTF, 0);

    wr(CTRL, 2); wr(CMP, 2); wr(CTRL, 1);
    tk(1020);
    wr(CEN, 1);
    tk(2);
    rchk("R7 top", CNT, 1023);
    tk(1);
    rchk("R7 wrap", CNT, 0);
    rchk("R7 wrap flag", INTF, 0);
    tk(2);
    rchk("R6 across wrap", INTF, 1);

    wr(CTRL, 0);
    wr(CAP, 32'hA5A5_0F0F);
    rchk("R10 cap", CAP, 32'hA5A5_0F0F);
    rd(CNT, held);
    wr(CNT, 32'h55);
    rchk("R10 cnt ro", CNT, held);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule